// File: doc/BRIEF.md
# Programming Link Serial Responder

This block is the device side of a two-wire, half-duplex serial link that a programming host uses to talk to an on-chip command processor. It runs on its own system clock and oversamples the host-supplied serial clock and the shared data line through synchronisers. Each command word of `WORD_W` bits arrives most significant bit first and is handed to the command processor over a valid/ready port. The processor marks the word that completes a command. From then on the responder holds the data line high as a busy level.

The processor delivers its response words over a second valid/ready port. Once the last word has arrived, the responder pulls the line low for a fixed number of system clocks. This pulse tells the host that a response is waiting. The responder then presents the response bits one at a time, in step with the host clock. After the final bit it releases the line and waits for the next command. It never times out: the line stays as it is until the host clocks it.

The pad is modelled as a data output, an output enable and a data input. The host owns the line whenever the enable is low. Command decoding and the work behind each command belong to the processor and are outside this block.

Top module: `prog_link_responder`

## Requirements
- R1: After reset the pad enable is low, `cmd_valid_o` is low and `rsp_ready_o` is low.
- R2: In the receive state, the data line is sampled on each host clock falling edge and shifted in most significant bit first. After `WORD_W` falling edges the word appears on `cmd_data_o` with `cmd_valid_o` high. Both stay unchanged until `cmd_ready_i` is seen high.
- R3: When a word is accepted with `cmd_end_i` low, the line stays released and the next word is received normally.
- R4: When a word is accepted with `cmd_end_i` high, the responder drives the line high (enable 1, data 1) until the response is complete. Host clock edges during this time change nothing.
- R5: `rsp_ready_o` is high only in the busy phase, and never while `cmd_valid_o` is high. Only one command is in flight at a time.
- R6: The cycle after the final response word is accepted, the line is driven low for exactly `PULSE_CYCLES` system clocks. After that the most significant bit of the first response word is driven.
- R7: Response bits are sent most significant bit first, words in the order they were supplied. Each host clock falling edge moves on to the next bit, so the host samples each bit on its rising edge.
- R8: After the falling edge that follows the last response bit, the pad enable goes low and the block returns to command receive.
- R9: Host clock edges while a received word waits for `cmd_ready_i` are ignored and do not corrupt the next word.
- R10: A response holds at most `RSP_DEPTH` words. Accepting word number `RSP_DEPTH` ends the response even when `rsp_last_i` is low.
- R11: There is no timeout. After the low pulse, the first response bit is held for any length of time until the host supplies a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_clk_i | input | 1 | Serial clock from the host (asynchronous) |
| host_dat_i | input | 1 | Data line as seen at the pad |
| dat_o | output | 1 | Data driven onto the line |
| dat_oe_o | output | 1 | Pad output enable (1 = responder drives the line) |
| cmd_valid_o | output | 1 | A received command word is available |
| cmd_data_o | output | WORD_W | Received command word |
| cmd_ready_i | input | 1 | Processor accepts the command word |
| cmd_end_i | input | 1 | The word being accepted completes the command |
| rsp_valid_i | input | 1 | Processor offers a response word |
| rsp_data_i | input | WORD_W | Response word |
| rsp_last_i | input | 1 | This response word is the last one |
| rsp_ready_o | output | 1 | Responder accepts a response word |

## Verification
The bench builds the block with `WORD_W` 16, two synchroniser stages, `RSP_DEPTH` 3 and `PULSE_CYCLES` 20. With the pulse this short, its exact width can be counted clock by clock within a short run. With a depth of only three, the forced end of a response at full depth (R10) is reached with a single three-word reply. Host clock half periods of six system clocks keep edge detection reliable. They also leave room to toggle the clock while a word is pending or while the processor is busy, which shows that those edges are ignored.

// File: rtl/plr_pkg.sv
package plr_pkg;
   typedef enum logic [2:0] {
      S_RECV,
      S_HAND,
      S_BUSY,
      S_FLAG,
      S_SEND
   } plr_state_e;
endpackage

// File: rtl/plr_sync_edge.sv
// Brings host clock and data into the system domain and flags host clock falls.
module plr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdat_i,
   output logic fall_o,
   output logic dat_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("plr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] c_ff;
   logic [STAGES-1:0] d_ff;
   logic              c_prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_ff[g] <= 1'b0;
               d_ff[g] <= 1'b1;
            end else begin
               c_ff[g] <= sclk_i;
               d_ff[g] <= sdat_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_ff[g] <= 1'b0;
               d_ff[g] <= 1'b1;
            end else begin
               c_ff[g] <= c_ff[g-1];
               d_ff[g] <= d_ff[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_prev <= 1'b0;
      else        c_prev <= c_ff[STAGES-1];
   end

   assign fall_o = c_prev & ~c_ff[STAGES-1];
   assign dat_o  = d_ff[STAGES-1];
endmodule

// File: rtl/plr_deser.sv
// Shifts in one command word, most significant bit first.
module plr_deser #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o
);
   localparam int            BW   = $clog2(WORD_W);
   localparam logic [BW-1:0] BMAX = BW'(WORD_W - 1);

   logic [WORD_W-1:0] sh;
   logic [BW-1:0]     cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (en_i) begin
         sh  <= {sh[WORD_W-2:0], bit_i};
         cnt <= (cnt == BMAX) ? '0 : cnt + 1'b1;
      end
   end

   assign word_o = sh;
   assign done_o = en_i && (cnt == BMAX);
endmodule

// File: rtl/plr_rsp_store.sv
// Holds one response and walks through its bits for transmission.
module plr_rsp_store #(
   parameter int WORD_W    = 16,
   parameter int RSP_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              wlast_i,
   input  logic              step_i,
   output logic              final_o,
   output logic              bit_o,
   output logic              on_last_o
);
   localparam int            IW   = (RSP_DEPTH > 1) ? $clog2(RSP_DEPTH) : 1;
   localparam int            BW   = $clog2(WORD_W);
   localparam logic [IW-1:0] WMAX = IW'(RSP_DEPTH - 1);
   localparam logic [BW-1:0] BMAX = BW'(WORD_W - 1);

   logic [WORD_W-1:0] mem [RSP_DEPTH];
   logic [IW-1:0]     wptr;
   logic [IW-1:0]     lastw;
   logic [IW-1:0]     ridx;
   logic [BW-1:0]     bidx;

   assign final_o = wr_i && (wlast_i || (wptr == WMAX));

   always_ff @(posedge clk) begin
      if (wr_i) mem[wptr] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         lastw <= '0;
         ridx  <= '0;
         bidx  <= BMAX;
      end else if (clear_i) begin
         wptr  <= '0;
         ridx  <= '0;
         bidx  <= BMAX;
      end else begin
         if (wr_i) begin
            if (final_o) lastw <= wptr;
            else         wptr  <= wptr + 1'b1;
         end
         if (step_i) begin
            if (bidx == '0) begin
               bidx <= BMAX;
               ridx <= ridx + 1'b1;
            end else begin
               bidx <= bidx - 1'b1;
            end
         end
      end
   end

   assign bit_o     = mem[ridx][bidx];
   assign on_last_o = (bidx == '0) && (ridx == lastw);

   assert_wptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wptr <= WMAX);
endmodule

// File: rtl/prog_link_responder.sv
module prog_link_responder #(
   parameter int WORD_W       = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int RSP_DEPTH    = 4,
   parameter int PULSE_CYCLES = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_clk_i,
   input  logic              host_dat_i,
   output logic              dat_o,
   output logic              dat_oe_o,
   output logic              cmd_valid_o,
   output logic [WORD_W-1:0] cmd_data_o,
   input  logic              cmd_ready_i,
   input  logic              cmd_end_i,
   input  logic              rsp_valid_i,
   input  logic [WORD_W-1:0] rsp_data_i,
   input  logic              rsp_last_i,
   output logic              rsp_ready_o
);
   import plr_pkg::*;

   localparam int            PW    = $clog2(PULSE_CYCLES + 1);
   localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYCLES - 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("prog_link_responder: WORD_W must be at least 2");
   end
   if (RSP_DEPTH < 1) begin : g_bad_depth
      $error("prog_link_responder: RSP_DEPTH must be at least 1");
   end
   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("prog_link_responder: PULSE_CYCLES must be at least 1");
   end

   plr_state_e    state;
   logic [PW-1:0] pcnt;
   logic          hfall, hdat;
   logic          word_done;
   logic          rsp_final, tx_bit, tx_on_last;
   logic          cmd_take, start_cmd, rsp_wr;

   plr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (host_clk_i),
      .sdat_i (host_dat_i),
      .fall_o (hfall),
      .dat_o  (hdat)
   );

   plr_deser #(.WORD_W(WORD_W)) u_deser (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (hfall && (state == S_RECV)),
      .bit_i  (hdat),
      .word_o (cmd_data_o),
      .done_o (word_done)
   );

   assign cmd_take  = (state == S_HAND) && cmd_ready_i;
   assign start_cmd = cmd_take && cmd_end_i;
   assign rsp_wr    = rsp_valid_i && rsp_ready_o;

   plr_rsp_store #(.WORD_W(WORD_W), .RSP_DEPTH(RSP_DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start_cmd),
      .wr_i      (rsp_wr),
      .wdata_i   (rsp_data_i),
      .wlast_i   (rsp_last_i),
      .step_i    (hfall && (state == S_SEND)),
      .final_o   (rsp_final),
      .bit_o     (tx_bit),
      .on_last_o (tx_on_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_RECV;
         pcnt  <= '0;
      end else begin
         unique case (state)
            S_RECV: if (word_done) state <= S_HAND;
            S_HAND: if (cmd_ready_i) state <= cmd_end_i ? S_BUSY : S_RECV;
            S_BUSY: if (rsp_final) begin
               state <= S_FLAG;
               pcnt  <= PLOAD;
            end
            S_FLAG: if (pcnt == '0) state <= S_SEND;
                    else            pcnt  <= pcnt - 1'b1;
            S_SEND: if (hfall && tx_on_last) state <= S_RECV;
            default: state <= S_RECV;
         endcase
      end
   end

   assign cmd_valid_o = (state == S_HAND);
   assign rsp_ready_o = (state == S_BUSY);
   assign dat_oe_o    = (state == S_BUSY) || (state == S_FLAG) || (state == S_SEND);
   assign dat_o       = (state == S_SEND) ? tx_bit : (state == S_BUSY);

   assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o)));

   assert_busy_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_oe_o) |-> dat_o);

   assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_ready_o && cmd_valid_o));

   assert_flag_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_i && rsp_ready_o && rsp_last_i) |=> (dat_oe_o && !dat_o));

   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_oe_o) |-> (!rsp_ready_o && !cmd_valid_o));
endmodule

// File: tb/prog_link_responder_tb.sv
module prog_link_responder_tb;
   localparam int W     = 16;
   localparam int DEPTH = 3;
   localparam int PULSE = 20;
   localparam int H     = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic host_d = 1'b1;
   logic host_oe = 1'b0;
   logic dut_o, dut_oe, cmd_valid, rsp_ready;
   logic [W-1:0] cmd_data;
   logic cmd_ready = 1'b0, cmd_end = 1'b0;
   logic rsp_valid = 1'b0, rsp_last = 1'b0;
   logic [W-1:0] rsp_data = '0;
   logic pad;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   assign pad = dut_oe ? dut_o : (host_oe ? host_d : 1'b1);

   prog_link_responder #(
      .WORD_W(W), .SYNC_STAGES(2), .RSP_DEPTH(DEPTH), .PULSE_CYCLES(PULSE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .host_clk_i(sclk), .host_dat_i(pad),
      .dat_o(dut_o), .dat_oe_o(dut_oe),
      .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data),
      .cmd_ready_i(cmd_ready), .cmd_end_i(cmd_end),
      .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .rsp_last_i(rsp_last),
      .rsp_ready_o(rsp_ready)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic host_pulse();
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic host_send(input logic [W-1:0] w);
      host_oe = 1'b1;
      for (int b = W - 1; b >= 0; b--) begin
         host_d = w[b];
         host_pulse();
      end
      host_oe = 1'b0;
   endtask

   task automatic proc_take(input logic [W-1:0] exp, input bit endf, input int toggles);
      int n = 0;
      while (!cmd_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(cmd_valid && cmd_data == exp, "R2 word", cmd_data, exp);
      host_oe = 1'b1;
      for (int t = 0; t < toggles; t++) begin
         host_d = t[0];
         host_pulse();
      end
      host_oe = 1'b0;
      repeat (4) @(negedge clk);
      chk(cmd_valid && cmd_data == exp, "R9 pending word kept", cmd_data, exp);
      chk(!rsp_ready, "R5 no rsp_ready while word pending", rsp_ready, 0);
      cmd_ready = 1'b1;
      cmd_end = endf;
      @(negedge clk);
      cmd_ready = 1'b0;
      cmd_end = 1'b0;
   endtask

   task automatic proc_respond(input logic [W-1:0] w, input bit last);
      rsp_valid = 1'b1;
      rsp_data = w;
      rsp_last = last;
      while (!rsp_ready) @(negedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_last = 1'b0;
   endtask

   task automatic pulse_check(input bit first_bit);
      int k = 0;
      while (dut_oe && !dut_o && k < PULSE + 5) begin
         k++;
         @(negedge clk);
      end
      if (first_bit) chk(k == PULSE, "R6 pulse width", k, PULSE);
      else           chk(k >= PULSE, "R6 pulse width min", k, PULSE);
      chk(!rsp_ready, "R5 rsp_ready low after response", rsp_ready, 0);
   endtask

   task automatic host_read(input logic [W-1:0] w0, input logic [W-1:0] w1,
                            input logic [W-1:0] w2, input int n);
      logic [W-1:0] w;
      for (int i = 0; i < n; i++) begin
         w = (i == 0) ? w0 : ((i == 1) ? w1 : w2);
         for (int b = W - 1; b >= 0; b--) begin
            sclk = 1'b1;
            chk(dut_oe && dut_o == w[b], "R7 response bit", {dut_oe, dut_o}, {1'b1, w[b]});
            repeat (H) @(negedge clk);
            sclk = 1'b0;
            repeat (H) @(negedge clk);
         end
      end
      repeat (4) @(negedge clk);
      chk(!dut_oe, "R8 line released", dut_oe, 0);
      chk(!cmd_valid && !rsp_ready, "R8 back to receive", {cmd_valid, rsp_ready}, 0);
   endtask

   task automatic busy_check(input int n, input int toggles);
      for (int i = 0; i < n; i++) begin
         chk(dut_oe && dut_o, "R4 busy high", {dut_oe, dut_o}, 2'b11);
         @(negedge clk);
      end
      for (int t = 0; t < toggles; t++) begin
         host_pulse();
         chk(dut_oe && dut_o && rsp_ready, "R4 host edges ignored while busy",
             {dut_oe, dut_o, rsp_ready}, 3'b111);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!dut_oe && !cmd_valid && !rsp_ready, "R1 reset state", {dut_oe, cmd_valid, rsp_ready}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!dut_oe && !rsp_ready, "R1 idle after reset", {dut_oe, rsp_ready}, 0);

      // Single-word command, single-word response, host delays clocking
      host_send(16'hA5C3);
      proc_take(16'hA5C3, 1'b1, 0);
      busy_check(10, 0);
      proc_respond(16'h8001, 1'b1);
      pulse_check(1'b1);
      repeat (300) @(negedge clk);
      chk(dut_oe && dut_o, "R11 first bit held without timeout", {dut_oe, dut_o}, 2'b11);
      host_read(16'h8001, 16'h0, 16'h0, 1);

      // Two-word command, pending-word clock noise, busy clock noise
      host_send(16'h1234);
      proc_take(16'h1234, 1'b0, 5);
      repeat (2) @(negedge clk);
      chk(!dut_oe, "R3 line released between command words", dut_oe, 0);
      host_send(16'hFEDC);
      proc_take(16'hFEDC, 1'b1, 0);
      busy_check(3, 3);
      proc_respond(16'h7F00, 1'b0);
      chk(dut_oe && dut_o && rsp_ready, "R4 still busy between response words",
          {dut_oe, dut_o, rsp_ready}, 3'b111);
      proc_respond(16'hC0DE, 1'b1);
      pulse_check(1'b0);
      host_read(16'h7F00, 16'hC0DE, 16'h0, 2);

      // Response reaches full depth without a last flag
      host_send(16'h0F0F);
      proc_take(16'h0F0F, 1'b1, 0);
      busy_check(2, 0);
      proc_respond(16'hFFFF, 1'b0);
      proc_respond(16'h0000, 1'b0);
      rsp_valid = 1'b1;
      rsp_data = 16'hB00B;
      rsp_last = 1'b0;
      while (!rsp_ready) @(negedge clk);
      @(negedge clk);
      chk(!rsp_ready && dut_oe && !dut_o, "R10 depth ends response",
          {rsp_ready, dut_oe, dut_o}, 3'b010);
      rsp_valid = 1'b0;
      pulse_check(1'b1);
      host_read(16'hFFFF, 16'h0000, 16'hB00B, 3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule